// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control around a successive-approximation analog-to-digital converter. A 4-bit control word sets the power bit, the mode, the trigger enable and the start bit. The start bit is set by software, by an external trigger pin or by an on-chip trigger event. Hardware also clears it at the end of a single conversion. The analog side is reduced to a sample strobe, a DAC code bus and a one-bit comparator input. The comparator reads 1 when the analog input is at or above the code being tried.

Each conversion runs a fixed sample phase. It then makes one bit decision per clock, starting at the most significant bit, and writes the result into a data register. In single mode the block stops after one result. In continuous mode it converts back to back until software clears the start bit. An active-low interrupt line gives a one-cycle falling edge when a single conversion ends, or when a continuous flow is stopped. A halt input forces the power bit off. With power off no conversion can start.

Top module: `sar_sequencer`

## Requirements
- R1: After reset all four control bits read 0, the data register is 0, `done` and `sample` are low and `irq_n` is high. Control word layout: bit 0 start, bit 1 continuous mode, bit 2 trigger enable, bit 3 power.
- R2: A conversion resolves bits from the MSB down. The first code tried is 2^(W-1). The stored result equals the largest code for which the comparator reads 1 (analog level >= code).
- R3: `sample` is high for exactly SAMPLE_CYC cycles. `done` is a one-cycle pulse seen W+SAMPLE_CYC+1 clock edges after the edge that writes start=1.
- R4: In single mode (bit 1 = 0) the start bit reads 0 from the cycle `done` is seen, and no further conversion follows.
- R5: In continuous mode (bit 1 = 1) conversions repeat every W+SAMPLE_CYC cycles. Each one overwrites the data register. Writing start=0 aborts the conversion in progress, leaves the data register unchanged and stops further results.
- R6: In single mode with `irq_en` high, `irq_n` is low for exactly the cycle in which `done` is high. With `irq_en` low, `irq_n` stays high.
- R7: In continuous mode with `irq_en` high, a write that clears a set start bit drives `irq_n` low for one cycle right after that write edge.
- R8: With trigger enable and power set, a falling edge on `ext_trig_n` at least 2 cycles wide starts a conversion. It passes a 2-stage synchronizer, and `done` follows W+8 edges after the pin falls.
- R9: With trigger enable and power set, a rising edge on `chip_trig` starts a conversion, and `done` follows W+6 edges later.
- R10: With trigger enable at 0, edges on either trigger input leave the start bit at 0 and start nothing.
- R11: A trigger arriving while the start bit is 1 neither restarts the conversion nor queues another one.
- R12: If `chip_trig` is high or the synchronized `ext_trig_n` is low when trigger enable goes from 0 to 1, a conversion starts at once.
- R13: While power is 0, a software start or a trigger leaves the start bit at 0, and no sampling occurs.
- R14: `halt` clears power and start on the next edge and abandons any conversion without changing the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: start, continuous, trigger enable, power (bit 0..3) |
| irq_en | input | 1 | Interrupt enable |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling-edge active |
| chip_trig | input | 1 | Synchronous on-chip trigger, rising-edge active |
| halt | input | 1 | Core halt; forces power off |
| cmp_in | input | 1 | Comparator: 1 when analog input >= dac_code |
| start_q | output | 1 | Start bit |
| cont_q | output | 1 | Continuous mode bit |
| trg_en_q | output | 1 | Trigger enable bit |
| pow_q | output | 1 | Power bit |
| sample | output | 1 | Sample-and-hold strobe |
| dac_code | output | W | Code under trial |
| data_q | output | W | Last conversion result |
| done | output | 1 | One-cycle end-of-conversion pulse |
| irq_n | output | 1 | Active-low interrupt edge |

## Verification
The search is run on every 10-bit input level, back to back in continuous mode. A wrong bit order, a dropped decision or a stale result shows as a mismatch on a single code. The spacing between results is also checked. Single conversions at the extremes and at alternating-bit patterns confirm the first trial code, the sample length and the latency. Each start source is tried on its own: software, a pin edge, an on-chip edge, and a level already present at enable. Each is also tried while it should be masked (trigger disabled, power off, already busy, halted), so that the measured latencies tell the paths apart.

// File: rtl/sar_sequencer.sv
`timescale 1ns/1ps
module sar_sequencer #(
  parameter int W = 10,
  parameter int SAMPLE_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [3:0]   ctl_wdata,
  input  logic         irq_en,
  input  logic         ext_trig_n,
  input  logic         chip_trig,
  input  logic         halt,
  input  logic         cmp_in,
  output logic         start_q,
  output logic         cont_q,
  output logic         trg_en_q,
  output logic         pow_q,
  output logic         sample,
  output logic [W-1:0] dac_code,
  output logic [W-1:0] data_q,
  output logic         done,
  output logic         irq_n
);
  localparam int CW = $clog2((W > SAMPLE_CYC) ? W : SAMPLE_CYC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV} state_t;
  state_t state;

  logic [CW-1:0] cnt;
  logic [W-1:0]  acc;
  logic [W-1:0]  trial;
  logic [2:0]    ext_s;
  logic          chip_d, trg_en_d;
  logic          ext_fall, chip_rise, en_rise, trig_hit;

  assign trial     = acc | (W'(1) << cnt);
  assign dac_code  = (state == S_CONV) ? trial : '0;
  assign sample    = (state == S_SAMP);
  assign ext_fall  = ext_s[2] & ~ext_s[1];
  assign chip_rise = chip_trig & ~chip_d;
  assign en_rise   = trg_en_q & ~trg_en_d;
  assign trig_hit  = trg_en_q & (ext_fall | chip_rise | (en_rise & (~ext_s[1] | chip_trig)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      acc      <= '0;
      data_q   <= '0;
      start_q  <= 1'b0;
      cont_q   <= 1'b0;
      trg_en_q <= 1'b0;
      pow_q    <= 1'b0;
      done     <= 1'b0;
      irq_n    <= 1'b1;
      ext_s    <= 3'b111;
      chip_d   <= 1'b0;
      trg_en_d <= 1'b0;
    end else begin
      ext_s    <= {ext_s[1:0], ext_trig_n};
      chip_d   <= chip_trig;
      trg_en_d <= trg_en_q;
      done     <= 1'b0;
      irq_n    <= 1'b1;

      if (trig_hit && pow_q && !start_q)
        start_q <= 1'b1;

      unique case (state)
        S_IDLE: if (start_q) begin
          state <= S_SAMP;
          cnt   <= '0;
        end
        S_SAMP: begin
          if (cnt == CW'(SAMPLE_CYC - 1)) begin
            state <= S_CONV;
            cnt   <= CW'(W - 1);
            acc   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CONV: begin
          if (cmp_in) acc <= trial;
          if (cnt == '0) begin
            data_q <= cmp_in ? trial : acc;
            done   <= 1'b1;
            if (cont_q) begin
              state <= S_SAMP;
            end else begin
              state   <= S_IDLE;
              start_q <= 1'b0;
              if (irq_en) irq_n <= 1'b0;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (ctl_we) begin
        start_q  <= ctl_wdata[0] & ctl_wdata[3];
        cont_q   <= ctl_wdata[1];
        trg_en_q <= ctl_wdata[2];
        pow_q    <= ctl_wdata[3];
        if (!(ctl_wdata[0] && ctl_wdata[3])) begin
          state <= S_IDLE;
          done  <= 1'b0;
          if (start_q && cont_q && irq_en) irq_n <= 1'b0;
        end
      end

      if (halt) begin
        pow_q   <= 1'b0;
        start_q <= 1'b0;
        state   <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/sar_sequencer_chk.sv
`timescale 1ns/1ps
module sar_sequencer_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctl_we,
  input logic         halt,
  input logic         start_q,
  input logic         cont_q,
  input logic         pow_q,
  input logic         sample,
  input logic         done,
  input logic         irq_n,
  input logic [W-1:0] data_q
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cont_q && !$past(ctl_we) && !$past(halt)) |-> !start_q);

  assert_data_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> done);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> irq_n);

  assert_start_needs_pow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> pow_q);

  assert_sample_needs_pow_R13: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> pow_q);

  assert_halt_pow_R14: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!pow_q && !start_q));
endmodule

bind sar_sequencer sar_sequencer_chk #(.W(W)) u_chk (.*);

// File: tb/sar_sequencer_tb.sv
`timescale 1ns/1ps
module sar_sequencer_tb;
  localparam int W  = 10;
  localparam int SC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n = 1'b0, ctl_we = 1'b0, irq_en = 1'b0;
  logic         ext_trig_n = 1'b1, chip_trig = 1'b0, halt = 1'b0;
  logic [3:0]   ctl_wdata = '0;
  logic         cmp_in, start_q, cont_q, trg_en_q, pow_q, sample, done, irq_n;
  logic [W-1:0] dac_code, data_q;
  int           vin = 0;
  int           tests = 0, fails = 0;

  assign cmp_in = (vin >= int'(dac_code));

  sar_sequencer #(.W(W), .SAMPLE_CYC(SC)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wait_done(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge clk); n++; @(negedge clk);
      if (done) return;
    end
    n = -1;
  endtask

  task automatic quiet(input int cyc, output bit seen);
    seen = 0;
    repeat (cyc) begin
      @(posedge clk); @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic pulse_chip(input int dly);
    fork
      begin
        repeat (dly) @(negedge clk);
        chip_trig = 1'b1;
        repeat (2) @(negedge clk);
        chip_trig = 1'b0;
      end
    join_none
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, ns, fd;
    bit seen;
    int pats[6] = '{0, 1023, 341, 682, 1, 512};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({start_q, cont_q, trg_en_q, pow_q} == 4'b0, "R1 ctl bits", {start_q, cont_q, trg_en_q, pow_q}, 0);
    check(data_q == 0 && !done && !sample, "R1 data/done/sample", data_q, 0);
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);

    wr(4'b0001);
    check(!start_q, "R13 start without power", start_q, 0);
    quiet(30, seen);
    check(!seen, "R13 no conversion without power", seen, 0);

    wr(4'b1000);
    foreach (pats[i]) begin
      vin = pats[i];
      wr(4'b1001);
      n = 0; ns = 0; fd = -1;
      while (n < 40) begin
        @(posedge clk); n++; @(negedge clk);
        ns += int'(sample);
        if (fd < 0 && dac_code != 0) fd = int'(dac_code);
        if (done) break;
      end
      check(n == W + SC + 1, "R3 latency", n, W + SC + 1);
      check(ns == SC, "R3 sample length", ns, SC);
      check(fd == (1 << (W - 1)), "R2 first trial code", fd, 1 << (W - 1));
      check(int'(data_q) == pats[i], "R2 single result", data_q, pats[i]);
      check(!start_q, "R4 start cleared", start_q, 0);
      check(irq_n, "R6 no irq when disabled", irq_n, 1);
      @(posedge clk); @(negedge clk);
      check(!done, "R3 done one cycle", done, 0);
    end
    quiet(30, seen);
    check(!seen, "R4 no repeat in single mode", seen, 0);

    irq_en = 1'b1; vin = 77;
    wr(4'b1001);
    wait_done(40, n);
    check(!irq_n, "R6 irq with done", irq_n, 0);
    @(posedge clk); @(negedge clk);
    check(irq_n, "R6 irq one cycle", irq_n, 1);

    vin = 0;
    wr(4'b1011);
    for (int v = 0; v < (1 << W); v++) begin
      wait_done(40, n);
      check(int'(data_q) == v, "R5 R2 continuous sweep", data_q, v);
      if (v > 0) check(n == W + SC, "R5 period", n, W + SC);
      if (v == 5) check(irq_n, "R6 no irq per result in continuous", irq_n, 1);
      vin = v + 1;
    end
    wr(4'b1010);
    check(!irq_n, "R7 stop irq", irq_n, 0);
    check(!start_q, "R5 stop clears start", start_q, 0);
    @(posedge clk); @(negedge clk);
    check(irq_n, "R7 irq one cycle", irq_n, 1);
    quiet(40, seen);
    check(!seen, "R5 no results after stop", seen, 0);

    irq_en = 1'b0; vin = 300;
    wr(4'b1011);
    wait_done(40, n);
    vin = 400;
    repeat (6) @(negedge clk);
    wr(4'b1010);
    quiet(40, seen);
    check(!seen && data_q == 300, "R5 abort keeps data", data_q, 300);

    wr(4'b1000);
    ext_trig_n = 1'b0; repeat (2) @(negedge clk); ext_trig_n = 1'b1;
    pulse_chip(0);
    quiet(40, seen);
    check(!seen && !start_q, "R10 triggers masked", seen, 0);

    wr(4'b1100);
    vin = 123;
    ext_trig_n = 1'b0;
    fork begin repeat (2) @(negedge clk); ext_trig_n = 1'b1; end join_none
    wait_done(40, n);
    check(n == W + 8, "R8 external trigger latency", n, W + 8);
    check(data_q == 123, "R8 external trigger result", data_q, 123);

    vin = 456;
    pulse_chip(0);
    wait_done(40, n);
    check(n == W + 6, "R9 on-chip trigger latency", n, W + 6);
    check(data_q == 456, "R9 on-chip trigger result", data_q, 456);

    quiet(5, seen);
    vin = 789;
    wr(4'b1101);
    pulse_chip(5);
    wait_done(40, n);
    check(n == W + SC + 1, "R11 busy trigger no restart", n, W + SC + 1);
    quiet(40, seen);
    check(!seen, "R11 busy trigger not queued", seen, 0);

    wr(4'b1000);
    chip_trig = 1'b1;
    quiet(10, seen);
    check(!seen, "R10 level masked", seen, 0);
    wr(4'b1100);
    wait_done(40, n);
    check(n == W + 6, "R12 on-chip level at enable", n, W + 6);
    chip_trig = 1'b0;
    wr(4'b1000);
    ext_trig_n = 1'b0;
    quiet(10, seen);
    wr(4'b1100);
    wait_done(40, n);
    check(n == W + 6, "R12 external level at enable", n, W + 6);
    ext_trig_n = 1'b1;
    quiet(5, seen);

    wr(4'b0100);
    pulse_chip(0);
    quiet(40, seen);
    check(!seen && !start_q, "R13 trigger without power", seen, 0);

    vin = 200;
    wr(4'b1011);
    wait_done(40, n);
    repeat (3) @(negedge clk);
    halt = 1'b1;
    @(posedge clk); @(negedge clk);
    halt = 1'b0;
    check(!pow_q && !start_q, "R14 halt clears power and start", {pow_q, start_q}, 0);
    quiet(40, seen);
    check(!seen && data_q == 200, "R14 halt abandons conversion", data_q, 200);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule